// File: doc/BRIEF.md
# Single-Cycle Instruction Control Decoder

This block turns one 32-bit instruction word into the full set of control signals for a single-cycle load/store core. It is purely combinational. It reads the 6-bit major opcode in bits [31:26] and the 6-bit function code in bits [5:0]. From these it chooses the destination register, the second ALU operand, the immediate extension, the ALU operation, memory read and write strobes, the register write enable, the writeback source and the next-PC source.

Register-format arithmetic takes its ALU operation from the function code. Immediate-format arithmetic takes it from the opcode. The two link instructions write PC+4: one writes it to the rd field, the other to the top register (31). Any write whose destination is register 0 is dropped. Any unrecognised encoding is made harmless: it writes nothing, touches no memory and advances the PC sequentially.

The block has no states. It is a three-stage decode made of a function-code classifier, an opcode decoder and a destination gate.

Top module: `instr_ctrl_decode`

## Requirements
- R1: With opcode 0x00, function codes 0x20/0x22/0x24/0x25/0x2A give alu_op 0 (add), 1 (sub), 2 (and), 3 (or) and 4 (slt). For these: dst_sel=1 (rd), alu_src_imm=0, wb_sel=0 (ALU), pc_sel=0 (sequential), no memory strobe, and reg_wr=1.
- R2: Opcode 0x08 (addi) gives alu_op 0 and opcode 0x0B (sltiu) gives alu_op 5 (unsigned less-than). Both give dst_sel=0 (rt), alu_src_imm=1, wb_sel=0, pc_sel=0 and reg_wr=1.
- R3: imm_zext=1 only for sltiu. ext_imm is instr[15:0] zero-extended when imm_zext=1 and sign-extended otherwise.
- R4: Opcode 0x23 (lw) gives alu_op 0, alu_src_imm=1, mem_rd=1, mem_wr=0, wb_sel=1 (memory), dst_sel=0 and reg_wr=1.
- R5: Opcode 0x2B (sw) gives alu_op 0, alu_src_imm=1, mem_wr=1, mem_rd=0 and reg_wr=0.
- R6: Opcode 0x04 (beq) gives alu_op 1 (subtract), alu_src_imm=0, pc_sel=1 (conditional branch), reg_wr=0 and no memory strobe.
- R7: Opcode 0x00 with function 0x08 (jr) gives pc_sel=2 (register target), alu_op 7 (unused), reg_wr=0 and no memory strobe.
- R8: Opcode 0x00 with function 0x09 (jalr) gives pc_sel=2, dst_sel=1, wb_sel=2 (PC+4), alu_op 7 and reg_wr=1.
- R9: Opcode 0x03 (jal) gives pc_sel=3 (absolute jump), dst_sel=2, wr_addr=31, wb_sel=2, alu_op 7 and reg_wr=1.
- R10: Any other opcode, or opcode 0x00 with any other function code, gives reg_wr=0, mem_rd=0, mem_wr=0, pc_sel=0, alu_op 7, alu_src_imm=0, dst_sel=0 and wb_sel=0.
- R11: When the selected destination address is 0, reg_wr is 0.
- R12: wr_addr is instr[20:16] for dst_sel=0, instr[15:11] for dst_sel=1 and 31 for dst_sel=2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| instr | input | 32 | Instruction word |
| dst_sel | output | 2 | Destination choice: 0 rt, 1 rd, 2 link register |
| wr_addr | output | 5 | Selected destination register address |
| alu_src_imm | output | 1 | 1: second ALU operand is ext_imm |
| imm_zext | output | 1 | 1: immediate zero-extended |
| ext_imm | output | 32 | Extended immediate |
| alu_op | output | 3 | ALU operation code |
| mem_rd | output | 1 | Memory read strobe |
| mem_wr | output | 1 | Memory write strobe |
| reg_wr | output | 1 | Register file write enable |
| wb_sel | output | 2 | Writeback source: 0 ALU, 1 memory, 2 PC+4 |
| pc_sel | output | 2 | Next PC: 0 sequential, 1 branch, 2 register, 3 jump target |

## Verification
The bench builds the block with its default parameters: a 32-bit word, 5-bit register addresses and link register 31. With 5-bit register fields, random rt and rd values land on register 0 often enough to exercise the write suppression, and directed cases cover it as well. With a 16-bit immediate, a random draw has an even chance of setting the sign bit, so both extension paths are reached for every immediate opcode. Opcode and function values are drawn mostly from the legal set and partly from the whole 6-bit space, so the unrecognised-encoding path is reached for both fields.

// File: rtl/ctl_dec_pkg.sv
package ctl_dec_pkg;
    localparam int OPC_W = 6;
    localparam int FN_W  = 6;

    typedef enum logic [2:0] {
        ALU_ADD  = 3'd0,
        ALU_SUB  = 3'd1,
        ALU_AND  = 3'd2,
        ALU_OR   = 3'd3,
        ALU_SLT  = 3'd4,
        ALU_SLTU = 3'd5,
        ALU_NOP  = 3'd7
    } alu_op_e;

    typedef enum logic [1:0] {DST_RT = 2'd0, DST_RD = 2'd1, DST_LINK = 2'd2} dst_e;
    typedef enum logic [1:0] {WB_ALU = 2'd0, WB_MEM = 2'd1, WB_LINK = 2'd2} wb_e;
    typedef enum logic [1:0] {PC_SEQ = 2'd0, PC_BR = 2'd1, PC_REG = 2'd2, PC_JMP = 2'd3} pc_e;
    typedef enum logic [1:0] {FK_ALU = 2'd0, FK_JR = 2'd1, FK_JALR = 2'd2, FK_BAD = 2'd3} fkind_e;

    localparam logic [OPC_W-1:0] OP_RTYPE = 6'h00;
    localparam logic [OPC_W-1:0] OP_JAL   = 6'h03;
    localparam logic [OPC_W-1:0] OP_BEQ   = 6'h04;
    localparam logic [OPC_W-1:0] OP_ADDI  = 6'h08;
    localparam logic [OPC_W-1:0] OP_SLTIU = 6'h0B;
    localparam logic [OPC_W-1:0] OP_LW    = 6'h23;
    localparam logic [OPC_W-1:0] OP_SW    = 6'h2B;

    localparam logic [FN_W-1:0] FN_JR   = 6'h08;
    localparam logic [FN_W-1:0] FN_JALR = 6'h09;
    localparam logic [FN_W-1:0] FN_ADD  = 6'h20;
    localparam logic [FN_W-1:0] FN_SUB  = 6'h22;
    localparam logic [FN_W-1:0] FN_AND  = 6'h24;
    localparam logic [FN_W-1:0] FN_OR   = 6'h25;
    localparam logic [FN_W-1:0] FN_SLT  = 6'h2A;

    typedef struct packed {
        dst_e    dst;
        logic    src_imm;
        logic    zext;
        alu_op_e op;
        logic    rd_en;
        logic    wr_en;
        logic    wr_raw;
        wb_e     wb;
        pc_e     pc;
    } ctl_t;
endpackage

// File: rtl/ctl_func_dec.sv
module ctl_func_dec
    import ctl_dec_pkg::*;
(
    input  logic [FN_W-1:0] fn,
    output fkind_e          kind,
    output alu_op_e         r_op
);
    always_comb begin
        kind = FK_ALU;
        r_op = ALU_NOP;
        unique case (fn)
            FN_ADD:  r_op = ALU_ADD;
            FN_SUB:  r_op = ALU_SUB;
            FN_AND:  r_op = ALU_AND;
            FN_OR:   r_op = ALU_OR;
            FN_SLT:  r_op = ALU_SLT;
            FN_JR:   kind = FK_JR;
            FN_JALR: kind = FK_JALR;
            default: kind = FK_BAD;
        endcase
    end
endmodule

// File: rtl/ctl_main_dec.sv
module ctl_main_dec
    import ctl_dec_pkg::*;
(
    input  logic [OPC_W-1:0] opc,
    input  fkind_e           kind,
    input  alu_op_e          r_op,
    output ctl_t             ctl
);
    always_comb begin
        ctl = '{dst: DST_RT, src_imm: 1'b0, zext: 1'b0, op: ALU_NOP,
                rd_en: 1'b0, wr_en: 1'b0, wr_raw: 1'b0, wb: WB_ALU, pc: PC_SEQ};
        unique case (opc)
            OP_RTYPE: begin
                unique case (kind)
                    FK_ALU: begin
                        ctl.dst    = DST_RD;
                        ctl.op     = r_op;
                        ctl.wr_raw = 1'b1;
                    end
                    FK_JR: ctl.pc = PC_REG;
                    FK_JALR: begin
                        ctl.dst    = DST_RD;
                        ctl.wb     = WB_LINK;
                        ctl.pc     = PC_REG;
                        ctl.wr_raw = 1'b1;
                    end
                    default: ;
                endcase
            end
            OP_ADDI, OP_SLTIU: begin
                ctl.src_imm = 1'b1;
                ctl.zext    = (opc == OP_SLTIU);
                ctl.op      = (opc == OP_SLTIU) ? ALU_SLTU : ALU_ADD;
                ctl.wr_raw  = 1'b1;
            end
            OP_LW: begin
                ctl.src_imm = 1'b1;
                ctl.op      = ALU_ADD;
                ctl.rd_en   = 1'b1;
                ctl.wb      = WB_MEM;
                ctl.wr_raw  = 1'b1;
            end
            OP_SW: begin
                ctl.src_imm = 1'b1;
                ctl.op      = ALU_ADD;
                ctl.wr_en   = 1'b1;
            end
            OP_BEQ: begin
                ctl.op = ALU_SUB;
                ctl.pc = PC_BR;
            end
            OP_JAL: begin
                ctl.dst    = DST_LINK;
                ctl.wb     = WB_LINK;
                ctl.pc     = PC_JMP;
                ctl.wr_raw = 1'b1;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/ctl_dest_gate.sv
module ctl_dest_gate
    import ctl_dec_pkg::*;
#(
    parameter int REG_AW   = 5,
    parameter int LINK_REG = (1 << REG_AW) - 1
) (
    input  dst_e              dst,
    input  logic [REG_AW-1:0] rt,
    input  logic [REG_AW-1:0] rd,
    input  logic              wr_raw,
    output logic [REG_AW-1:0] wr_addr,
    output logic              reg_wr
);
    localparam logic [REG_AW-1:0] LINK_A = REG_AW'(LINK_REG);

    always_comb begin
        unique case (dst)
            DST_RD:   wr_addr = rd;
            DST_LINK: wr_addr = LINK_A;
            default:  wr_addr = rt;
        endcase
        reg_wr = wr_raw && (wr_addr != '0);
    end
endmodule

// File: rtl/instr_ctrl_decode.sv
module instr_ctrl_decode
    import ctl_dec_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int REG_AW = 5,
    parameter int IMM_W  = 16
) (
    input  logic [DATA_W-1:0] instr,
    output logic [1:0]        dst_sel,
    output logic [REG_AW-1:0] wr_addr,
    output logic              alu_src_imm,
    output logic              imm_zext,
    output logic [DATA_W-1:0] ext_imm,
    output logic [2:0]        alu_op,
    output logic              mem_rd,
    output logic              mem_wr,
    output logic              reg_wr,
    output logic [1:0]        wb_sel,
    output logic [1:0]        pc_sel
);
    localparam int OPC_LSB = DATA_W - OPC_W;
    localparam int RS_LSB  = OPC_LSB - REG_AW;
    localparam int RT_LSB  = RS_LSB - REG_AW;
    localparam int RD_LSB  = RT_LSB - REG_AW;
    localparam int PAD_W   = DATA_W - IMM_W;

    logic [OPC_W-1:0]  opc;
    logic [FN_W-1:0]   fn;
    logic [REG_AW-1:0] rt, rd;
    logic [IMM_W-1:0]  imm;
    logic              unused_fields;
    fkind_e            kind;
    alu_op_e           r_op;
    ctl_t              ctl;

    assign opc = instr[DATA_W-1:OPC_LSB];
    assign rt  = instr[RT_LSB +: REG_AW];
    assign rd  = instr[RD_LSB +: REG_AW];
    assign fn  = instr[FN_W-1:0];
    assign imm = instr[IMM_W-1:0];
    assign unused_fields = ^{instr[RS_LSB +: REG_AW], instr[RD_LSB-1:FN_W]};

    ctl_func_dec i_fn (.fn(fn), .kind(kind), .r_op(r_op));

    ctl_main_dec i_main (.opc(opc), .kind(kind), .r_op(r_op), .ctl(ctl));

    ctl_dest_gate #(.REG_AW(REG_AW)) i_dest (
        .dst(ctl.dst), .rt(rt), .rd(rd), .wr_raw(ctl.wr_raw),
        .wr_addr(wr_addr), .reg_wr(reg_wr)
    );

    assign ext_imm     = ctl.zext ? {{PAD_W{1'b0}}, imm} : {{PAD_W{imm[IMM_W-1]}}, imm};
    assign dst_sel     = ctl.dst;
    assign alu_src_imm = ctl.src_imm;
    assign imm_zext    = ctl.zext;
    assign alu_op      = ctl.op;
    assign mem_rd      = ctl.rd_en;
    assign mem_wr      = ctl.wr_en;
    assign wb_sel      = ctl.wb;
    assign pc_sel      = ctl.pc;
endmodule

// File: rtl/ctl_decode_chk.sv
module ctl_decode_chk #(
    parameter int DATA_W = 32,
    parameter int REG_AW = 5
) (
    input logic [DATA_W-1:0] instr,
    input logic [REG_AW-1:0] wr_addr,
    input logic              imm_zext,
    input logic [2:0]        alu_op,
    input logic              mem_rd,
    input logic              mem_wr,
    input logic              reg_wr,
    input logic [1:0]        wb_sel,
    input logic [1:0]        pc_sel
);
    always_comb begin
        if (!$isunknown(instr)) begin
            AST_MEM_EXCL:    assert (!(mem_rd && mem_wr)) else $error("rd and wr together");        // R4
            AST_MEMRD_WB:    assert (!mem_rd || wb_sel == 2'd1) else $error("load not from memory");  // R4
            AST_STORE_NOWR:  assert (!mem_wr || !reg_wr) else $error("store writes register");     // R5
            AST_ZEXT_SLTU:   assert (!imm_zext || alu_op == 3'd5) else $error("zext off sltiu");   // R3
            AST_BRANCH:      assert (pc_sel != 2'd1 || (alu_op == 3'd1 && !reg_wr)) else $error("bad branch"); // R6
            AST_LINK_JUMP:   assert (wb_sel != 2'd2 || pc_sel >= 2'd2) else $error("link without jump"); // R8
            AST_ZERO_DEST:   assert (!reg_wr || wr_addr != '0) else $error("write to r0");          // R11
        end
    end
endmodule

bind instr_ctrl_decode ctl_decode_chk #(.DATA_W(DATA_W), .REG_AW(REG_AW)) i_chk (
    .instr(instr), .wr_addr(wr_addr), .imm_zext(imm_zext), .alu_op(alu_op),
    .mem_rd(mem_rd), .mem_wr(mem_wr), .reg_wr(reg_wr), .wb_sel(wb_sel), .pc_sel(pc_sel)
);

// File: tb/test_instr_ctrl_decode.sv
module test_instr_ctrl_decode;
    logic        clk = 1'b0;
    logic [31:0] instr;
    logic [1:0]  dst_sel, wb_sel, pc_sel;
    logic [4:0]  wr_addr;
    logic        alu_src_imm, imm_zext, mem_rd, mem_wr, reg_wr;
    logic [31:0] ext_imm;
    logic [2:0]  alu_op;
    int          n_chk = 0, n_bad = 0;
    bit          done = 1'b0;

    always #5 clk = ~clk;

    instr_ctrl_decode i_instr_ctrl_decode (
        .instr(instr), .dst_sel(dst_sel), .wr_addr(wr_addr), .alu_src_imm(alu_src_imm),
        .imm_zext(imm_zext), .ext_imm(ext_imm), .alu_op(alu_op), .mem_rd(mem_rd),
        .mem_wr(mem_wr), .reg_wr(reg_wr), .wb_sel(wb_sel), .pc_sel(pc_sel)
    );

    // packed: dst(2) addr(5) src(1) zext(1) imm(32) op(3) rd(1) wr(1) rw(1) wb(2) pc(2)
    function automatic logic [50:0] model(input logic [31:0] w);
        logic [5:0] op = w[31:26], fn = w[5:0];
        logic [1:0] d = 0, wb = 0, pc = 0;
        logic [2:0] a = 7;
        logic s = 0, z = 0, mr = 0, mw = 0, raw = 0;
        logic [4:0] ad;
        logic [31:0] ei;
        case (op)
            6'h00: case (fn)
                6'h20: begin d = 1; a = 0; raw = 1; end
                6'h22: begin d = 1; a = 1; raw = 1; end
                6'h24: begin d = 1; a = 2; raw = 1; end
                6'h25: begin d = 1; a = 3; raw = 1; end
                6'h2A: begin d = 1; a = 4; raw = 1; end
                6'h08: pc = 2;
                6'h09: begin d = 1; wb = 2; pc = 2; raw = 1; end
                default: ;
            endcase
            6'h08: begin s = 1; a = 0; raw = 1; end
            6'h0B: begin s = 1; z = 1; a = 5; raw = 1; end
            6'h23: begin s = 1; a = 0; mr = 1; wb = 1; raw = 1; end
            6'h2B: begin s = 1; a = 0; mw = 1; end
            6'h04: begin a = 1; pc = 1; end
            6'h03: begin d = 2; wb = 2; pc = 3; raw = 1; end
            default: ;
        endcase
        ad = (d == 0) ? w[20:16] : (d == 1) ? w[15:11] : 5'd31;
        ei = z ? {16'h0, w[15:0]} : {{16{w[15]}}, w[15:0]};
        return {d, ad, s, z, ei, a, mr, mw, raw && (ad != 0), wb, pc};
    endfunction

    function automatic string tag(input logic [31:0] w);
        case (w[31:26])
            6'h00: return (w[5:0] == 6'h08) ? "R7" : (w[5:0] == 6'h09) ? "R8" :
                          (w[5:0] inside {6'h20, 6'h22, 6'h24, 6'h25, 6'h2A}) ? "R1" : "R10";
            6'h08, 6'h0B: return "R2/R3";
            6'h23: return "R4";
            6'h2B: return "R5";
            6'h04: return "R6";
            6'h03: return "R9";
            default: return "R10";
        endcase
    endfunction

    task automatic apply(input logic [31:0] w, input string rq);
        logic [50:0] got, exp;
        @(posedge clk);
        instr = w;
        @(negedge clk);
        got = {dst_sel, wr_addr, alu_src_imm, imm_zext, ext_imm, alu_op,
               mem_rd, mem_wr, reg_wr, wb_sel, pc_sel};
        exp = model(w);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s/R12/R11 instr=%h actual=%h expected=%h", rq, w, got, exp);
        end
    endtask

    function automatic logic [31:0] mk(input logic [5:0] op, input logic [4:0] rt,
                                       input logic [4:0] rd, input logic [15:0] lo);
        return {op, 5'd7, rt, rd, lo[10:0]};
    endfunction

    initial begin
        instr = 32'h0;
        // idle word: opcode 0, function 0 is unrecognised, so all inactive (R10)
        apply(32'h0, "R10");
        apply(mk(6'h00, 5'd3, 5'd4, 16'h0020), "R1");
        apply(mk(6'h00, 5'd3, 5'd4, 16'h002A), "R1");
        apply(mk(6'h00, 5'd3, 5'd0, 16'h0022), "R11");
        apply(mk(6'h08, 5'd9, 5'd16, 16'h8001), "R3");
        apply(mk(6'h0B, 5'd9, 5'd16, 16'h8001), "R3");
        apply(mk(6'h08, 5'd0, 5'd1, 16'h0004), "R11");
        apply(mk(6'h23, 5'd2, 5'd1, 16'hFFFC), "R4");
        apply(mk(6'h2B, 5'd2, 5'd1, 16'h0010), "R5");
        apply(mk(6'h04, 5'd2, 5'd1, 16'hFFFF), "R6");
        apply(mk(6'h00, 5'd0, 5'd0, 16'h0008), "R7");
        apply(mk(6'h00, 5'd0, 5'd5, 16'h0009), "R8");
        apply(mk(6'h00, 5'd0, 5'd0, 16'h0009), "R8/R11");
        apply(mk(6'h03, 5'd0, 5'd0, 16'h1234), "R9");
        apply(mk(6'h3F, 5'd6, 5'd6, 16'h0020), "R10");
        apply(mk(6'h00, 5'd6, 5'd6, 16'h0021), "R10");
        begin
            logic [5:0] ops [7] = '{6'h00, 6'h08, 6'h0B, 6'h23, 6'h2B, 6'h04, 6'h03};
            logic [5:0] fns [7] = '{6'h08, 6'h09, 6'h20, 6'h22, 6'h24, 6'h25, 6'h2A};
            void'($urandom(32'd2024));
            for (int i = 0; i < 2000; i++) begin
                logic [31:0] w = $urandom;
                if ($urandom_range(0, 9) != 0) w[31:26] = ops[$urandom_range(0, 6)];
                if ($urandom_range(0, 9) != 0) w[5:0] = fns[$urandom_range(0, 6)];
                apply(w, tag(w));
            end
        end
        done = 1'b1;
    end

    initial begin
        for (int c = 0; c < 100000 && !done; c++) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=hung expected=done");
        end
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule